// File: doc/BRIEF.md
# Zero-Suppressing Seven-Segment Display Decoder

This block turns a row of BCD digits into active-low segment drives for a fixed-point numeric display. The integer part holds `INT_DIGITS` digits and the fraction part `FRAC_DIGITS` digits. Each digit goes through its own decoder cell. The cells are linked by a ripple-blanking net. On the integer side, zeros to the left of the first significant digit go dark. On the fraction side, zeros to the right of the last significant digit go dark. Zeros that sit between significant digits stay lit.

Every cell has three controls. The first is a ripple-blanking input that arrives from its neighbour. The second is a blanking input shared by the whole display. The third is a lamp-test input shared by the whole display. Inside a cell, the blanking input and the ripple-blanking output are modelled as one wired net. So a cell that is forced dark also tells its downstream neighbour that it is blank. The integer chain starts at the most significant digit. The fraction chain starts at the least significant digit. The integer units digit is never suppressed, so an all-zero value reads as a single `0`.

The block is purely combinational. Segment current, resistors and display scanning belong to the surrounding logic.

Top module: `bcd7_display`

## Requirements
- R1: A digit code from 0 to 9 gives the standard seven-segment glyph, active low, with bit 0 = segment a up to bit 6 = segment g. Active-low words for 0..9 are 40,79,24,30,19,12,02,78,00,10 (hex). The 6 shows its top bar and the 9 shows its bottom bar.
- R2: A digit code from 10 to 15 turns all seven segments off (7F hex).
- R3: With `blank_n` low, every segment of every digit is off, whatever the digits and the lamp-test input are.
- R4: With `lamp_test_n` low and `blank_n` high, every segment of every digit is lit (00 hex), and no zero suppression takes place.
- R5: An integer digit other than the units digit is dark when it is zero and every more significant integer digit is also zero.
- R6: An integer zero that has a nonzero code somewhere to its left is displayed as a 0.
- R7: The integer units digit (lowest four bits of `int_bcd`) is never suppressed, so an all-zero integer part shows as 0.
- R8: A fraction digit is dark when it is zero and every less significant fraction digit is also zero. The least significant fraction digit sits in the lowest four bits of `frac_bcd`.
- R9: A fraction zero that has a nonzero code somewhere to its right is displayed as a 0.
- R10: An invalid code (10 to 15) counts as significant for suppression. It ends the blanking run even though the code itself is shown dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_bcd | input | INT_DIGITS*4 | Integer digits; the most significant digit is in the top nibble |
| frac_bcd | input | FRAC_DIGITS*4 | Fraction digits; the top nibble is the first digit after the point |
| lamp_test_n | input | 1 | Active-low lamp test for all digits |
| blank_n | input | 1 | Active-low forced blanking for all digits |
| int_seg_n | output | INT_DIGITS*7 | Active-low segments of the integer digits, 7 bits per digit |
| frac_seg_n | output | FRAC_DIGITS*7 | Active-low segments of the fraction digits, 7 bits per digit |

## Verification
The bench targets the edges of each blanking run. The cases include a zero right after the first significant digit, such as 0105 and 5.50, and the all-zero integer and fraction parts. A chain that propagated the wrong way, or that kept blanking after a significant digit, would darken a significant zero or leave a leading or trailing zero lit. The bench also puts an invalid code in the middle of a run of zeros; a design that treated such a code as zero would wrongly blank the zeros below it. Finally, it drives blanking and lamp test together, and the units digit at zero, to catch an inverted priority or a units digit that disappears. An exhaustive sweep over all integer codes compares the result against an independent model of the run rules.

// File: rtl/bcd7_pkg.sv
`timescale 1ns/1ps
package bcd7_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  // Active-high glyph, bit 0 = a ... bit 6 = g.
  function automatic logic [SEG_W-1:0] seg_pattern(input logic [BCD_W-1:0] code);
    logic [SEG_W-1:0] lit;
    case (code)
      4'd0: lit = 7'b0111111;
      4'd1: lit = 7'b0000110;
      4'd2: lit = 7'b1011011;
      4'd3: lit = 7'b1001111;
      4'd4: lit = 7'b1100110;
      4'd5: lit = 7'b1101101;
      4'd6: lit = 7'b1111101;
      4'd7: lit = 7'b0000111;
      4'd8: lit = 7'b1111111;
      4'd9: lit = 7'b1101111;
      default: lit = 7'b0000000;
    endcase
    return lit;
  endfunction

  function automatic logic is_decimal(input logic [BCD_W-1:0] code);
    return code <= 4'd9;
  endfunction
endpackage

// File: rtl/bcd7_cell.sv
`timescale 1ns/1ps
module bcd7_cell
  import bcd7_pkg::*;
(
  input  logic [BCD_W-1:0] digit,
  input  logic             lt_n,
  input  logic             rbi_n,
  input  logic             bi_n,
  output logic [SEG_W-1:0] seg_n,
  output logic             rbo_n
);
  logic zero_hit;
  logic lamp_on;

  always_comb begin
    lamp_on  = bi_n & ~lt_n;
    zero_hit = (digit == '0) & ~rbi_n & lt_n;
    // Wired net: pulled low by external blanking or by a suppressed zero.
    rbo_n    = bi_n & ~zero_hit;
    if (!rbo_n)       seg_n = '1;
    else if (lamp_on) seg_n = '0;
    else              seg_n = ~seg_pattern(digit);
  end

  always_comb begin
    if (!bi_n) AST_BLANK_DARK: assert (seg_n == '1); // R3
    if (bi_n && !lt_n) AST_LAMP_LIT: assert (seg_n == '0 && rbo_n); // R4
    if (bi_n && !rbo_n) AST_SUPPRESS_DARK: assert (seg_n == '1 && digit == '0); // R5
    if (bi_n && lt_n && !is_decimal(digit)) AST_BAD_CODE_DARK: assert (seg_n == '1 && rbo_n); // R2
    if (bi_n && lt_n && rbi_n) AST_ZERO_KEPT: assert (seg_n != '1 || !is_decimal(digit)); // R6
  end
endmodule

// File: rtl/bcd7_chain.sv
`timescale 1ns/1ps
module bcd7_chain
  import bcd7_pkg::*;
#(
  parameter int DIGITS  = 4,
  parameter bit LEADING = 1'b1
) (
  input  logic [DIGITS*BCD_W-1:0] bcd,
  input  logic                    lt_n,
  input  logic                    bi_n,
  output logic [DIGITS*SEG_W-1:0] seg_n
);
  localparam int TOP = DIGITS - 1;

  logic [DIGITS-1:0] rbi_n;
  logic [DIGITS-1:0] rbo_n;

  for (genvar i = 0; i < DIGITS; i++) begin : g_cell
    if (LEADING) begin : g_lead
      // Runs from the most significant digit downward; the units digit is kept.
      if (i == 0)        begin : g_units assign rbi_n[i] = 1'b1;         end
      else if (i == TOP) begin : g_head  assign rbi_n[i] = 1'b0;         end
      else               begin : g_link  assign rbi_n[i] = rbo_n[i+1];   end
    end else begin : g_trail
      // Runs from the least significant fraction digit upward.
      if (i == 0) begin : g_head assign rbi_n[i] = 1'b0;       end
      else        begin : g_link assign rbi_n[i] = rbo_n[i-1]; end
    end

    bcd7_cell u_cell (
      .digit (bcd[i*BCD_W +: BCD_W]),
      .lt_n  (lt_n),
      .rbi_n (rbi_n[i]),
      .bi_n  (bi_n),
      .seg_n (seg_n[i*SEG_W +: SEG_W]),
      .rbo_n (rbo_n[i])
    );

    if (LEADING && i == 0) begin : g_units_chk
      always_comb begin
        if (bi_n && lt_n && is_decimal(bcd[BCD_W-1:0]))
          AST_UNITS_SHOWN: assert (seg_n[SEG_W-1:0] != '1); // R7
      end
    end

    if (LEADING && i > 0 && i < TOP) begin : g_lead_chk
      always_comb begin
        if (bi_n && lt_n && !rbo_n[i])
          AST_LEAD_RUN: assert (!rbo_n[i+1]); // R5
      end
    end

    if (!LEADING && i > 0) begin : g_trail_chk
      always_comb begin
        if (bi_n && lt_n && !rbo_n[i])
          AST_TRAIL_RUN: assert (!rbo_n[i-1]); // R8
      end
    end
  end
endmodule

// File: rtl/bcd7_display.sv
`timescale 1ns/1ps
module bcd7_display
  import bcd7_pkg::*;
#(
  parameter int INT_DIGITS  = 4,
  parameter int FRAC_DIGITS = 2
) (
  input  logic [INT_DIGITS*4-1:0]  int_bcd,
  input  logic [FRAC_DIGITS*4-1:0] frac_bcd,
  input  logic                     lamp_test_n,
  input  logic                     blank_n,
  output logic [INT_DIGITS*7-1:0]  int_seg_n,
  output logic [FRAC_DIGITS*7-1:0] frac_seg_n
);
  bcd7_chain #(.DIGITS(INT_DIGITS), .LEADING(1'b1)) u_int (
    .bcd   (int_bcd),
    .lt_n  (lamp_test_n),
    .bi_n  (blank_n),
    .seg_n (int_seg_n)
  );

  bcd7_chain #(.DIGITS(FRAC_DIGITS), .LEADING(1'b0)) u_frac (
    .bcd   (frac_bcd),
    .lt_n  (lamp_test_n),
    .bi_n  (blank_n),
    .seg_n (frac_seg_n)
  );

  always_comb begin
    if (!blank_n) AST_ALL_DARK: assert (int_seg_n == '1 && frac_seg_n == '1); // R3
    if (blank_n && !lamp_test_n) AST_ALL_LIT: assert (int_seg_n == '0 && frac_seg_n == '0); // R4
  end
endmodule

// File: tb/bcd7_display_bench.sv
`timescale 1ns/1ps
module bcd7_display_bench;
  localparam int NI = 4;
  localparam int NF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI*4-1:0] int_bcd = '0;
  logic [NF*4-1:0] frac_bcd = '0;
  logic lamp_test_n = 1'b1;
  logic blank_n = 1'b1;
  logic [NI*7-1:0] int_seg_n;
  logic [NF*7-1:0] frac_seg_n;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd7_display u_bcd7_display (
    .int_bcd(int_bcd), .frac_bcd(frac_bcd), .lamp_test_n(lamp_test_n),
    .blank_n(blank_n), .int_seg_n(int_seg_n), .frac_seg_n(frac_seg_n)
  );

  function automatic logic [6:0] glyph(input logic [3:0] d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; 9: return 7'h10;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic logic [NI*7-1:0] model_int(input logic [NI*4-1:0] v, input logic lt, input logic bl);
    logic [NI*7-1:0] r;
    bit run = 1'b1;
    for (int i = NI-1; i >= 0; i--) begin
      if (v[i*4 +: 4] != 0) run = 1'b0;
      if (!bl) r[i*7 +: 7] = 7'h7F;
      else if (!lt) r[i*7 +: 7] = 7'h00;
      else if (run && i != 0) r[i*7 +: 7] = 7'h7F;
      else r[i*7 +: 7] = glyph(v[i*4 +: 4]);
    end
    return r;
  endfunction

  function automatic logic [NF*7-1:0] model_frac(input logic [NF*4-1:0] v, input logic lt, input logic bl);
    logic [NF*7-1:0] r;
    bit run = 1'b1;
    for (int j = 0; j < NF; j++) begin
      if (v[j*4 +: 4] != 0) run = 1'b0;
      if (!bl) r[j*7 +: 7] = 7'h7F;
      else if (!lt) r[j*7 +: 7] = 7'h00;
      else if (run) r[j*7 +: 7] = 7'h7F;
      else r[j*7 +: 7] = glyph(v[j*4 +: 4]);
    end
    return r;
  endfunction

  task automatic drive(input logic [NI*4-1:0] iv, input logic [NF*4-1:0] fv, input logic lt, input logic bl);
    @(posedge clk);
    int_bcd = iv; frac_bcd = fv; lamp_test_n = lt; blank_n = bl;
    @(negedge clk);
  endtask

  task automatic cmp(input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (int=%h frac=%h lt=%b bl=%b)",
               req, got, exp, int_bcd, frac_bcd, lamp_test_n, blank_n);
    end
  endtask

  task automatic apply_model(input string req, input logic [NI*4-1:0] iv, input logic [NF*4-1:0] fv,
                             input logic lt, input logic bl);
    drive(iv, fv, lt, bl);
    cmp(req, 64'(int_seg_n), 64'(model_int(iv, lt, bl)));
    cmp(req, 64'(frac_seg_n), 64'(model_frac(fv, lt, bl)));
  endtask

  task automatic t_reset_state();
    drive('0, '0, 1'b1, 1'b1);
    cmp("R7 idle", 64'(int_seg_n), 64'({7'h7F, 7'h7F, 7'h7F, 7'h40}));
    cmp("R8 idle", 64'(frac_seg_n), 64'({7'h7F, 7'h7F}));
  endtask

  task automatic t_glyphs();
    for (int d = 1; d < 10; d++) begin
      drive({4{4'(d)}}, {2{4'(d)}}, 1'b1, 1'b1);
      cmp("R1 int", 64'(int_seg_n), 64'({4{glyph(4'(d))}}));
      cmp("R1 frac", 64'(frac_seg_n), 64'({2{glyph(4'(d))}}));
    end
    drive(16'h1000, 8'h01, 1'b1, 1'b1);
    cmp("R1 zero", 64'(int_seg_n), 64'({7'h79, 7'h40, 7'h40, 7'h40}));
  endtask

  task automatic t_invalid();
    drive(16'hBCDE, 8'hFA, 1'b1, 1'b1);
    cmp("R2 int", 64'(int_seg_n), 64'({4{7'h7F}}));
    cmp("R2 frac", 64'(frac_seg_n), 64'({2{7'h7F}}));
    drive(16'h0A00, 8'h0C, 1'b1, 1'b1);
    cmp("R10 int", 64'(int_seg_n), 64'({7'h7F, 7'h7F, 7'h40, 7'h40}));
    cmp("R10 frac", 64'(frac_seg_n), 64'({7'h40, 7'h7F}));
  endtask

  task automatic t_blank();
    drive(16'h1234, 8'h56, 1'b0, 1'b0);
    cmp("R3 int", 64'(int_seg_n), 64'({4{7'h7F}}));
    cmp("R3 frac", 64'(frac_seg_n), 64'({2{7'h7F}}));
    drive(16'h8888, 8'h88, 1'b1, 1'b0);
    cmp("R3 int", 64'(int_seg_n), 64'({4{7'h7F}}));
  endtask

  task automatic t_lamp();
    drive(16'h0000, 8'h00, 1'b0, 1'b1);
    cmp("R4 int", 64'(int_seg_n), 64'(0));
    cmp("R4 frac", 64'(frac_seg_n), 64'(0));
    drive(16'h0F00, 8'hE0, 1'b0, 1'b1);
    cmp("R4 int", 64'(int_seg_n), 64'(0));
  endtask

  task automatic t_leading();
    drive(16'h0105, 8'h00, 1'b1, 1'b1);
    cmp("R5 R6", 64'(int_seg_n), 64'({7'h7F, 7'h79, 7'h40, 7'h12}));
    drive(16'h0010, 8'h00, 1'b1, 1'b1);
    cmp("R5 R6", 64'(int_seg_n), 64'({7'h7F, 7'h7F, 7'h79, 7'h40}));
    drive(16'h0000, 8'h30, 1'b1, 1'b1);
    cmp("R7", 64'(int_seg_n), 64'({7'h7F, 7'h7F, 7'h7F, 7'h40}));
  endtask

  task automatic t_trailing();
    drive(16'h0005, 8'h50, 1'b1, 1'b1);
    cmp("R8", 64'(frac_seg_n), 64'({7'h12, 7'h7F}));
    drive(16'h0005, 8'h05, 1'b1, 1'b1);
    cmp("R9", 64'(frac_seg_n), 64'({7'h40, 7'h12}));
  endtask

  task automatic t_sweep();
    for (int v = 0; v < 65536; v++)
      apply_model("R5 R6 R8 R9 sweep", 16'(v), 8'(v), 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_glyphs();
    t_invalid();
    t_blank();
    t_lamp();
    t_leading();
    t_trailing();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule